// File: doc/BRIEF.md
# Packed Byte Add/Subtract Unit

This block performs four independent byte-wide additions or subtractions on two 32-bit operands in a single operation. Each byte lane is widened by one bit before the arithmetic. The widening is zero-extension or sign-extension, depending on whether the operation is unsigned or signed. The low byte of each widened lane result becomes the matching byte of the 32-bit output. No carry or borrow passes from one lane to the next.

Each arithmetic operation also writes a 4-bit greater-or-equal flag register, one bit per lane. A separate select operation reads those flags as a lane mask. For each lane it takes the byte from the first operand when the flag is set, and from the second operand when the flag is clear. A compare-then-merge sequence therefore needs two operations and no extra logic outside the block.

Top module: `pbyte_alu`

## Requirements
- R1: Lane i occupies bits 8i+7..8i of each operand and of the result. Each result byte is the low 8 bits of that lane's widened result, and no carry or borrow crosses a lane boundary.
- R2: Operation code 1 (unsigned add) zero-extends both lane bytes, adds them, and sets flag i to the lane carry-out (bit 8 of the widened sum).
- R3: Operation code 0 (signed add) sign-extends both lane bytes, adds them, and sets flag i when the widened sum is zero or positive.
- R4: Operation code 3 (unsigned subtract) computes first minus second per lane, and sets flag i exactly when the first operand's byte is at least the second's as unsigned numbers.
- R5: Operation code 2 (signed subtract) sign-extends both lane bytes, subtracts, and sets flag i when the widened difference is zero or positive.
- R6: Operation code 4 (select) makes result byte i equal to the first operand's byte i when flag i is 1, and equal to the second operand's byte i otherwise. It leaves the flag register unchanged.
- R7: Operation codes 5, 6 and 7 give a zero result and leave the flag register unchanged.
- R8: The result and the flag update appear on the clock edge that samples `in_vld` high. `out_vld` is high for exactly the cycle after each cycle in which `in_vld` was high.
- R9: While `rst_n` is low, the flag register, `out_vld` and `out_res` are all zero.
- R10: When `in_vld` is low, the flag register and `out_res` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operation request strobe |
| op | input | 3 | Operation code (0 sadd, 1 uadd, 2 ssub, 3 usub, 4 select) |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| out_vld | output | 1 | Result valid, one cycle per request |
| out_res | output | 32 | Registered 32-bit result |
| ge_flags | output | 4 | Per-lane greater-or-equal flag register |

## Verification
The result, `out_vld` and the flags are all due one rising edge after a request. The bench therefore drives each request at a falling edge and checks all three outputs at the next falling edge, half a period after they were registered. Because select reads the flags left by the previous operation, the bench's model updates its own flags only after scoring that operation, so it always compares against the flags the hardware held when the select was sampled. The idle cycles that test `out_vld` dropping and the flags holding are also checked at falling edges.

// File: rtl/pbyte_pkg.sv
package pbyte_pkg;

    typedef enum logic [2:0] {
        OP_SADD = 3'd0,
        OP_UADD = 3'd1,
        OP_SSUB = 3'd2,
        OP_USUB = 3'd3,
        OP_SEL  = 3'd4
    } op_e;

endpackage

// File: rtl/pbyte_lane.sv
module pbyte_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_sub,
    input  logic         is_signed,
    output logic [W-1:0] res,
    output logic         ge
);

    logic [W:0] ax;
    logic [W:0] bx;
    logic [W:0] wide;

    always_comb begin
        ax   = is_signed ? {a[W-1], a} : {1'b0, a};
        bx   = is_signed ? {b[W-1], b} : {1'b0, b};
        wide = is_sub ? (ax - bx) : (ax + bx);
        res  = wide[W-1:0];
        // unsigned add reports the carry; every other variant reports "not negative"
        ge   = (!is_signed && !is_sub) ? wide[W] : ~wide[W];
    end

endmodule

// File: rtl/pbyte_select.sv
module pbyte_select #(
    parameter int LANES = 4,
    parameter int W     = 8
) (
    input  logic [LANES*W-1:0] a,
    input  logic [LANES*W-1:0] b,
    input  logic [LANES-1:0]   ge,
    output logic [LANES*W-1:0] y
);

    logic [LANES*W-1:0] mask;

    for (genvar i = 0; i < LANES; i++) begin : g_mask
        assign mask[i*W +: W] = {W{ge[i]}};
    end

    assign y = (a & mask) | (b & ~mask);

endmodule

// File: rtl/pbyte_alu.sv
module pbyte_alu
    import pbyte_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [2:0]              op,
    input  logic [LANES*LANE_W-1:0] a,
    input  logic [LANES*LANE_W-1:0] b,
    output logic                    out_vld,
    output logic [LANES*LANE_W-1:0] out_res,
    output logic [LANES-1:0]        ge_flags
);

    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        logic             vld;
        logic [DW-1:0]    res;
        logic [LANES-1:0] ge;
    } state_t;

    state_t state_d, state_q;

    logic             arith_sub_d;
    logic             arith_signed_d;
    logic [DW-1:0]    arith_res_d;
    logic [LANES-1:0] arith_ge_d;
    logic [DW-1:0]    sel_res_d;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        pbyte_lane #(.W(LANE_W)) u_lane (
            .a         (a[i*LANE_W +: LANE_W]),
            .b         (b[i*LANE_W +: LANE_W]),
            .is_sub    (arith_sub_d),
            .is_signed (arith_signed_d),
            .res       (arith_res_d[i*LANE_W +: LANE_W]),
            .ge        (arith_ge_d[i])
        );
    end

    pbyte_select #(.LANES(LANES), .W(LANE_W)) u_sel (
        .a  (a),
        .b  (b),
        .ge (state_q.ge),
        .y  (sel_res_d)
    );

    always_comb begin
        op_e opc;
        opc            = op_e'(op);
        arith_sub_d    = (opc == OP_SSUB) || (opc == OP_USUB);
        arith_signed_d = (opc == OP_SADD) || (opc == OP_SSUB);

        state_d     = state_q;
        state_d.vld = in_vld;
        if (in_vld) begin
            case (opc)
                OP_SADD, OP_UADD, OP_SSUB, OP_USUB: begin
                    state_d.res = arith_res_d;
                    state_d.ge  = arith_ge_d;
                end
                OP_SEL:  state_d.res = sel_res_d;
                default: state_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_vld  = state_q.vld;
    assign out_res  = state_q.res;
    assign ge_flags = state_q.ge;

endmodule

// File: rtl/pbyte_alu_chk.sv
module pbyte_alu_chk #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_vld,
    input logic [2:0]              op,
    input logic [LANES*LANE_W-1:0] a,
    input logic [LANES*LANE_W-1:0] b,
    input logic                    out_vld,
    input logic [LANES*LANE_W-1:0] out_res,
    input logic [LANES-1:0]        ge_flags
);

    p_vld_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == $past(in_vld));

    p_sel_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op == 3'd4) |=> $stable(ge_flags));

    p_bad_op_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op > 3'd4) |=> (out_res == '0 && $stable(ge_flags)));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(ge_flags) && $stable(out_res)));

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        p_usub_ge_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && op == 3'd3) |=>
                ge_flags[i] == ($past(a[i*LANE_W +: LANE_W]) >= $past(b[i*LANE_W +: LANE_W])));

        p_uadd_lane_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && op == 3'd1) |=>
                out_res[i*LANE_W +: LANE_W] ==
                    LANE_W'($past(a[i*LANE_W +: LANE_W]) + $past(b[i*LANE_W +: LANE_W])));
    end

endmodule

bind pbyte_alu pbyte_alu_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .op       (op),
    .a        (a),
    .b        (b),
    .out_vld  (out_vld),
    .out_res  (out_res),
    .ge_flags (ge_flags)
);

// File: tb/pbyte_alu_test.sv
module pbyte_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        out_vld;
    logic [31:0] out_res;
    logic [3:0]  ge_flags;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [3:0] model_ge = 4'b0;

    always #4 clk = ~clk;

    pbyte_alu uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .a(a), .b(b),
        .out_vld(out_vld), .out_res(out_res), .ge_flags(ge_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected result and flags, computed lane by lane with integer arithmetic
    task automatic model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                         input logic [3:0] gin, output logic [31:0] r, output logic [3:0] g);
        r = '0;
        g = gin;
        for (int i = 0; i < 4; i++) begin
            int xv, yv, s;
            logic [7:0] xb, yb;
            xb = x[i*8 +: 8];
            yb = y[i*8 +: 8];
            if (o == 3'd0 || o == 3'd2) begin
                xv = (xb >= 8'd128) ? int'(xb) - 256 : int'(xb);
                yv = (yb >= 8'd128) ? int'(yb) - 256 : int'(yb);
            end else begin
                xv = int'(xb);
                yv = int'(yb);
            end
            s = (o == 3'd0 || o == 3'd1) ? xv + yv : xv - yv;
            if (o <= 3'd3) begin
                r[i*8 +: 8] = 8'(s & 255);
                g[i] = (o == 3'd1) ? (s >= 256) : (s >= 0);
            end else if (o == 3'd4) begin
                r[i*8 +: 8] = gin[i] ? xb : yb;
            end
        end
    endtask

    function automatic string tag(input logic [2:0] o);
        case (o)
            3'd0: return "R3";
            3'd1: return "R2";
            3'd2: return "R5";
            3'd3: return "R4";
            3'd4: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Drive at a falling edge, check at the next falling edge (one register stage)
    task automatic apply(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [31:0] er;
        logic [3:0]  eg;
        model(o, x, y, model_ge, er, eg);
        op = o; a = x; b = y; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check({tag(o), " result (R1 lanes)"}, out_res, er);
        check({tag(o), " flags"}, {28'd0, ge_flags}, {28'd0, eg});
        check("R8 out_vld high", {31'd0, out_vld}, 32'd1);
        model_ge = eg;
    endtask

    task automatic idle_check();
        logic [31:0] held;
        held = out_res;
        op = 3'd1; a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; in_vld = 1'b0;
        @(negedge clk);
        check("R8 out_vld low when idle", {31'd0, out_vld}, 32'd0);
        check("R10 flags held", {28'd0, ge_flags}, {28'd0, model_ge});
        check("R10 result held", out_res, held);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        check("R9 reset flags", {28'd0, ge_flags}, 32'd0);
        check("R9 reset out_vld", {31'd0, out_vld}, 32'd0);
        check("R9 reset result", out_res, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        apply(3'd1, 32'hFF80_7F01, 32'h0180_7FFF);
        apply(3'd4, 32'hAABB_CCDD, 32'h1122_3344);
        apply(3'd0, 32'h8080_7F7F, 32'h8001_7F80);
        apply(3'd2, 32'h807F_0000, 32'h7F80_0000);
        apply(3'd3, 32'h0001_FF00, 32'h0100_FF01);
        apply(3'd4, 32'hAABB_CCDD, 32'h1122_3344);
        idle_check();
        for (int o = 5; o < 8; o++) begin
            apply(3'(o), 32'h1234_5678, 32'h9ABC_DEF0);
        end
        idle_check();

        // Near-exhaustive sweep: every first-operand byte against a stepped second byte
        for (int o = 0; o < 4; o++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y += 5) begin
                    logic [7:0] xb, yb;
                    xb = 8'(x);
                    yb = 8'(y);
                    apply(3'(o), {~xb, xb ^ 8'h55, yb, xb}, {~yb, yb, xb, yb});
                    if (y == 0 && (x % 8) == 0) begin
                        apply(3'd4, {xb, 8'hC3, yb, 8'h5A}, {yb, 8'h3C, xb, 8'hA5});
                    end
                end
            end
            idle_check();
        end

        // Reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset flags again", {28'd0, ge_flags}, 32'd0);
        check("R9 reset result again", out_res, 32'd0);
        rst_n = 1'b1;
        model_ge = 4'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule